// File: doc/BRIEF.md
# Flash Buffered-Write Programming Sequencer

This block sits on the host side of a NOR-style flash with 16-bit words and programs a short run of words into a single sector through the flash's buffered-write command. When it receives a start request, it captures a sector address and a word count. It then issues the command sequence on a simple synchronous flash bus in a fixed order:

1. two unlock writes;
2. the buffer-load command;
3. the word count minus one;
4. every address/data pair, in order;
5. the confirm command.

It reads the address/data pairs from a small table that the host holds. The block presents a table index, and the host returns the matching pair combinationally in the same cycle.

After the confirm command, the sequencer polls status by reading at the last address it loaded. It reaches a decision from status bits 7, 5 and 1, and reports pass, fail or abort. On an abort it issues the three-write abort-reset sequence before it reports, so that the flash is back in read mode. An abort has two causes: the flash signals that the buffered write aborted, or a table entry points outside the chosen sector. It rejects a word count outside 1 to 32 at once with an error flag and drives no bus cycle.

Top module: `fbuf_prog_seq`

## Requirements
- R1: After reset, `busy`, `done`, `fl_we`, `fl_re`, `pass`, `fail`, `abort` and `err` are all 0.
- R2: An accepted start produces four single-cycle writes in this order, one per clock: 0x00AA to word address 0x555, 0x0055 to 0x2AA, command 0x0025 to the sector address, and then the word count minus one (zero-extended) to the sector address.
- R3: After the header, the pairs are written one per cycle in table index order 0 to N-1. Each write uses the table's address and data. The next cycle then writes 0x0029 to the sector address.
- R4: Status reads assert `fl_re` at the last loaded address, and the data is sampled on the following clock. If bit 7 equals bit 7 of the last loaded data, the result is pass. If bit 7 differs and bits 5 and 1 are both 0, the block polls again.
- R5: If bit 7 differs and bit 5 is 1, the block makes exactly one more read. A matching bit 7 on that read gives pass; otherwise the result is fail.
- R6: If bit 7 differs, bit 5 is 0 and bit 1 is 1, the block writes 0x00AA to 0x555, 0x0055 to 0x2AA and 0x00F0 to 0x555, and then reports abort.
- R7: A sector is given by address bits [22:15]. When a table entry's sector differs from the start sector, that pair is not written, no later pair is written, and the abort-reset writes of R6 follow and abort is reported.
- R8: A start with a count of 0 or more than 32 raises `done` and `err` on the next cycle and drives no bus cycle.
- R9: `done` is a one-cycle pulse in the cycle after the last bus or status decision. `pass`, `fail`, `abort` and `err` hold until the next accepted start. A start while `busy` is ignored.
- R10: `fl_we` and `fl_re` are never asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| start | input | 1 | start request, sampled while idle |
| sect_addr | input | 23 | word address inside the target sector |
| word_cnt | input | 6 | number of words to program |
| tbl_idx | output | 5 | index of the pair being loaded |
| tbl_addr | input | 23 | word address of the indexed pair |
| tbl_data | input | 16 | data of the indexed pair |
| fl_addr | output | 23 | flash word address |
| fl_wdata | output | 16 | flash write data |
| fl_we | output | 1 | flash write strobe, one cycle per write |
| fl_re | output | 1 | flash read strobe |
| fl_rdata | input | 16 | flash read data, valid the clock after `fl_re` |
| busy | output | 1 | sequence in progress |
| done | output | 1 | one-cycle completion pulse |
| pass | output | 1 | program succeeded |
| fail | output | 1 | program failed after the bit-5 re-read |
| abort | output | 1 | buffered write aborted and reset issued |
| err | output | 1 | word count out of range |

## Verification
An accepted start with N words and a first status read that matches raises `done` 8+N clocks after the start edge. Each extra poll adds two clocks, and a rejected count raises `done` after one clock. The bench counts clocks from the start edge to `done` and compares the count with these figures. It samples every output at the falling edge, so each registered result is read half a cycle after the edge that produced it. A flash model in the bench logs each write strobe and answers each read strobe with the next queued status word one clock later. This lets the checks compare the whole write order, the read count and the read address against lists built from the requirements.

// File: rtl/fbuf_prog_seq.sv
module fbuf_prog_seq #(
  parameter int AW = 23,
  parameter int DW = 16,
  parameter int IW = 5,
  parameter int SECT_LSB = 15,
  localparam int CW = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] sect_addr,
  input  logic [CW-1:0] word_cnt,
  output logic [IW-1:0] tbl_idx,
  input  logic [AW-1:0] tbl_addr,
  input  logic [DW-1:0] tbl_data,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_wdata,
  output logic          fl_we,
  output logic          fl_re,
  input  logic [DW-1:0] fl_rdata,
  output logic          busy,
  output logic          done,
  output logic          pass,
  output logic          fail,
  output logic          abort,
  output logic          err
);
  localparam logic [CW-1:0] MAXC = CW'(1 << IW);
  localparam logic [AW-1:0] UA1 = AW'(12'h555);
  localparam logic [AW-1:0] UA2 = AW'(12'h2AA);

  typedef enum logic [3:0] {
    S_IDLE, S_UL1, S_UL2, S_CMD, S_CNT, S_LOAD, S_CONF,
    S_RD1, S_CK1, S_RD2, S_CK2, S_AR1, S_AR2, S_AR3
  } st_t;

  st_t           state;
  logic [AW-1:0] sect_q, last_a;
  logic [CW-1:0] cnt_q, rem;
  logic [IW-1:0] idx;
  logic          last_d7;
  logic          in_sect, dq7_ok;
  logic          unused_rd;

  assign in_sect   = tbl_addr[AW-1:SECT_LSB] == sect_q[AW-1:SECT_LSB];
  assign dq7_ok    = fl_rdata[7] == last_d7;
  assign tbl_idx   = idx;
  assign busy      = state != S_IDLE;
  assign unused_rd = ^{fl_rdata[DW-1:8], fl_rdata[6], fl_rdata[4:2], fl_rdata[0]};

  always_comb begin
    fl_we = 1'b0;
    fl_re = 1'b0;
    fl_addr = '0;
    fl_wdata = '0;
    case (state)
      S_UL1, S_AR1: begin fl_we = 1'b1; fl_addr = UA1; fl_wdata = DW'(8'hAA); end
      S_UL2, S_AR2: begin fl_we = 1'b1; fl_addr = UA2; fl_wdata = DW'(8'h55); end
      S_AR3:  begin fl_we = 1'b1; fl_addr = UA1; fl_wdata = DW'(8'hF0); end
      S_CMD:  begin fl_we = 1'b1; fl_addr = sect_q; fl_wdata = DW'(8'h25); end
      S_CNT:  begin fl_we = 1'b1; fl_addr = sect_q; fl_wdata = DW'(cnt_q - 1'b1); end
      S_LOAD: if (in_sect) begin fl_we = 1'b1; fl_addr = tbl_addr; fl_wdata = tbl_data; end
      S_CONF: begin fl_we = 1'b1; fl_addr = sect_q; fl_wdata = DW'(8'h29); end
      S_RD1, S_RD2: begin fl_re = 1'b1; fl_addr = last_a; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      sect_q <= '0;
      last_a <= '0;
      cnt_q <= '0;
      rem <= '0;
      idx <= '0;
      last_d7 <= 1'b0;
      done <= 1'b0;
      pass <= 1'b0;
      fail <= 1'b0;
      abort <= 1'b0;
      err <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          {pass, fail, abort, err} <= 4'b0;
          if (word_cnt == '0 || word_cnt > MAXC) begin
            err <= 1'b1;
            done <= 1'b1;
          end else begin
            sect_q <= sect_addr;
            cnt_q <= word_cnt;
            rem <= word_cnt;
            idx <= '0;
            state <= S_UL1;
          end
        end
        S_UL1: state <= S_UL2;
        S_UL2: state <= S_CMD;
        S_CMD: state <= S_CNT;
        S_CNT: state <= S_LOAD;
        S_LOAD: if (!in_sect) state <= S_AR1;
        else begin
          last_a <= tbl_addr;
          last_d7 <= tbl_data[7];
          rem <= rem - 1'b1;
          idx <= idx + 1'b1;
          if (rem == CW'(1)) state <= S_CONF;
        end
        S_CONF: state <= S_RD1;
        S_RD1: state <= S_CK1;
        S_CK1: if (dq7_ok) begin
          pass <= 1'b1; done <= 1'b1; state <= S_IDLE;
        end else if (fl_rdata[5]) state <= S_RD2;
        else if (fl_rdata[1]) state <= S_AR1;
        else state <= S_RD1;
        S_RD2: state <= S_CK2;
        S_CK2: begin
          pass <= dq7_ok; fail <= !dq7_ok; done <= 1'b1; state <= S_IDLE;
        end
        S_AR1: state <= S_AR2;
        S_AR2: state <= S_AR3;
        S_AR3: begin abort <= 1'b1; done <= 1'b1; state <= S_IDLE; end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_we_re_excl_r10: assert property (@(posedge clk) disable iff (!rst_n) !(fl_we && fl_re));
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(cnt_q));
  p_err_nobus_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (!fl_we && !$past(fl_we)));
  p_rem_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_LOAD) |-> (rem != '0 && rem <= MAXC));
  p_poll_after_conf_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_we && state == S_CONF) |=> (fl_re && fl_addr == last_a));
  p_fail_second_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fail) |-> $past(state == S_CK2));
  p_abort_tail_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && abort) |-> ($past(fl_we) && $past(fl_wdata) == DW'(8'hF0)));
endmodule

// File: tb/tb_fbuf_prog_seq.sv
`timescale 1ns/1ps
module tb_fbuf_prog_seq;
  logic clk = 0, rst_n = 0, start = 0;
  logic [22:0] sect_addr = '0;
  logic [5:0] word_cnt = '0;
  logic [4:0] tbl_idx;
  logic [22:0] tbl_addr, fl_addr;
  logic [15:0] tbl_data, fl_wdata, fl_rdata;
  logic fl_we, fl_re, busy, done, pass, fail, abort, err;

  logic [22:0] taddr [32];
  logic [15:0] tdata [32];
  logic [15:0] resp [256];
  logic [22:0] wa [1024];
  logic [15:0] wd [1024];
  int nw = 0, nr = 0;
  logic [22:0] rd_a = '0;
  int checks = 0, failures = 0, cyc;

  always #4 clk = ~clk;

  assign tbl_addr = taddr[tbl_idx];
  assign tbl_data = tdata[tbl_idx];

  fbuf_prog_seq dut (.*);

  always @(posedge clk) begin
    if (fl_we) begin wa[nw] <= fl_addr; wd[nw] <= fl_wdata; nw <= nw + 1; end
    if (fl_re) begin fl_rdata <= resp[nr[7:0]]; rd_a <= fl_addr; nr <= nr + 1; end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic chkw(input int i, input logic [22:0] a, input logic [15:0] d, input string req);
    chk(wa[i] == a && wd[i] == d, req, {wa[i], wd[i]}, {a, d});
  endtask

  function automatic logic [15:0] st(input bit b7, input bit b5, input bit b1);
    return {8'h00, b7, 1'b0, b5, 3'b000, b1, 1'b0};
  endfunction

  task automatic fill(input logic [22:0] sect, input int n, input int bad);
    for (int i = 0; i < 32; i++) begin
      taddr[i] = (i == bad) ? sect + 23'h8000 + 23'(i) : sect + 23'(i * 3);
      tdata[i] = 16'h1234 + 16'(i * 16'h0147);
    end
    if (n == 0) taddr[0] = sect;
  endtask

  task automatic run(input logic [22:0] sect, input logic [5:0] n, input bit poke);
    @(negedge clk);
    sect_addr = sect; word_cnt = n; start = 1;
    @(negedge clk);
    start = 0; cyc = 1;
    while (!done && cyc < 500) begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 3) begin start = 1; word_cnt = 6'd2; end
      else start = 0;
    end
  endtask

  task automatic chk_head(input int b, input logic [22:0] sect, input int n, input string req);
    chkw(b, 23'h555, 16'h00AA, req);
    chkw(b + 1, 23'h2AA, 16'h0055, req);
    chkw(b + 2, sect, 16'h0025, req);
    chkw(b + 3, sect, 16'(n - 1), req);
  endtask

  task automatic chk_tail(input int b, input string req);
    chkw(b, 23'h555, 16'h00AA, req);
    chkw(b + 1, 23'h2AA, 16'h0055, req);
    chkw(b + 2, 23'h555, 16'h00F0, req);
  endtask

  task automatic t_reset;
    chk({busy, done, fl_we, fl_re, pass, fail, abort, err} == 8'h00, "R1 reset",
        {busy, done, fl_we, fl_re, pass, fail, abort, err}, 0);
  endtask

  task automatic t_single;
    int bw = nw, br = nr;
    logic [22:0] s = 23'h048000;
    fill(s, 1, -1);
    resp[br[7:0]] = st(tdata[0][7], 0, 0);
    run(s, 1, 0);
    chk(cyc == 9, "R9 single done latency", cyc, 9);
    chk(pass && !fail && !abort && !err, "R4 single pass", {pass, fail, abort, err}, 4'b1000);
    chk_head(bw, s, 1, "R2 single header");
    chkw(bw + 4, taddr[0], tdata[0], "R3 single pair");
    chkw(bw + 5, s, 16'h0029, "R3 single confirm");
    chk(nw - bw == 6 && nr - br == 1, "R4 single counts", {nw - bw, nr - br}, {6, 1});
    @(negedge clk); @(negedge clk);
    chk(pass && !done, "R9 flags hold", {pass, done}, 2'b10);
  endtask

  task automatic t_multi_poll;
    int bw = nw, br = nr;
    logic [22:0] s = 23'h210000;
    fill(s, 4, -1);
    resp[br[7:0]] = st(~tdata[3][7], 0, 0);
    resp[8'(br + 1)] = st(tdata[3][7], 0, 0);
    run(s, 4, 1);
    chk(cyc == 14, "R9 busy poll latency, restart ignored", cyc, 14);
    chk_head(bw, s, 4, "R2 multi header");
    for (int i = 0; i < 4; i++) chkw(bw + 4 + i, taddr[i], tdata[i], "R3 multi pair order");
    chkw(bw + 8, s, 16'h0029, "R3 multi confirm");
    chk(nr - br == 2 && rd_a == taddr[3], "R4 repoll at last address", rd_a, taddr[3]);
    chk(pass && nw - bw == 9, "R4 multi pass", {pass, nw - bw}, {1'b1, 9});
  endtask

  task automatic t_dq5(input bit good);
    int bw = nw, br = nr;
    logic [22:0] s = 23'h3F8000;
    fill(s, 2, -1);
    resp[br[7:0]] = st(~tdata[1][7], 1, 0);
    resp[8'(br + 1)] = st(good ? tdata[1][7] : ~tdata[1][7], 1, 1);
    run(s, 2, 0);
    chk(nr - br == 2, "R5 exactly one re-read", nr - br, 2);
    chk(pass == good && fail == !good && !abort, "R5 re-read result",
        {pass, fail, abort}, {good, !good, 1'b0});
    chk(nw - bw == 7, "R5 no extra writes", nw - bw, 7);
  endtask

  task automatic t_dq1;
    int bw = nw, br = nr;
    logic [22:0] s = 23'h100000;
    fill(s, 3, -1);
    resp[br[7:0]] = st(~tdata[2][7], 0, 1);
    run(s, 3, 0);
    chk(abort && !pass && !fail, "R6 abort flag", {abort, pass, fail}, 3'b100);
    chk(nr - br == 1 && nw - bw == 11, "R6 counts", {nr - br, nw - bw}, {1, 11});
    chk_tail(bw + 8, "R6 abort reset writes");
  endtask

  task automatic t_sector;
    int bw = nw, br = nr;
    logic [22:0] s = 23'h048000;
    fill(s, 4, 2);
    run(s, 4, 0);
    chk(abort && !pass, "R7 sector abort flag", {abort, pass}, 2'b10);
    chk(nw - bw == 9 && nr == br, "R7 pair skipped, no reads", {nw - bw, nr - br}, {9, 0});
    chkw(bw + 5, taddr[1], tdata[1], "R7 last good pair");
    chk_tail(bw + 6, "R7 abort reset writes");
  endtask

  task automatic t_max;
    int bw = nw, br = nr;
    logic [22:0] s = 23'h7F8000;
    fill(s, 32, -1);
    resp[br[7:0]] = st(tdata[31][7], 0, 0);
    run(s, 32, 0);
    chk(pass && cyc == 40, "R3 32-word pass", {pass, cyc}, {1'b1, 40});
    chkw(bw + 3, s, 16'd31, "R2 count word for 32");
    chkw(bw + 35, taddr[31], tdata[31], "R3 pair 31");
    chkw(bw + 36, s, 16'h0029, "R3 32-word confirm");
  endtask

  task automatic t_range(input logic [5:0] n);
    int bw = nw, br = nr;
    run(23'h048000, n, 0);
    chk(cyc == 1 && err && !pass && !abort, "R8 range reject",
        {cyc, err, pass, abort}, {1, 1'b1, 1'b0, 1'b0});
    chk(nw == bw && nr == br, "R8 no bus cycle", {nw - bw, nr - br}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R9 act=hung exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_single;
    t_multi_poll;
    t_dq5(1);
    t_dq5(0);
    t_dq1;
    t_sector;
    t_max;
    t_range(6'd0);
    t_range(6'd33);
    t_single;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule